// File: doc/BRIEF.md
# Serial Test Configuration Controller

This block sits in a daisy chain of identical controllers, one beside each router test wrapper. A 2-bit symbol stream arrives on a ready/valid input. Each accepted symbol enters a shift register of `4*NDIR + ID_DIGITS + 2` positions at the top. The register moves one position toward position 0, and the symbol that falls off position 0 goes out on a ready/valid output to the next controller. Symbols 0 to 2 carry ordinary configuration digits. Symbol 3 marks the end of a frame.

When an end-of-frame symbol reaches the top position, the controller compares the base-3 identifier field with its own `NODE_ID`. On a match it decodes the frame into control values for `NDIR` input cells and `NDIR` output cells:
- a 2-bit mode per cell;
- a 1-bit mux select per cell;
- a one-cycle strobe for each channel it writes.

Frames addressed to other nodes leave the controls unchanged and simply pass along the chain.

Top module: `scfg_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the frame register, sets every cell mode to 0 (normal), clears every mux control, every strobe and `out_valid`.
- R2: A symbol is accepted when `in_valid` and `in_ready` are both high, where `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While the output is stalled, `out_valid` and `out_sym` hold and no symbol is lost or duplicated.
- R3: Each accepted symbol enters the top position, and every other position moves down by one. One cycle later the previous content of position 0 appears on `out_sym` with `out_valid` high. The chain therefore forwards frames intact, delayed by one frame length.
- R4: The frame layout by position, with 0 the least significant, is as follows.
  - Position 0 holds the mode.
  - For direction d, with NORTH=0, EAST=1, SOUTH=2, WEST=3, RES=4:
    - input mux symbol at 4d+1;
    - input enable at 4d+2;
    - output mux symbol at 4d+3;
    - output enable at 4d+4.
  - The identifier occupies 4*NDIR+1 up to 4*NDIR+ID_DIGITS, least significant digit lowest.
  - The top position holds the end-of-frame symbol 3.
- R5: Controls are written only in the cycle after an accept that leaves symbol 3 in the top position and makes the identifier digits equal `NODE_ID` in base 3. Any other frame writes nothing.
- R6: On a match with mode symbol 0 (normal) or 2 (bypass), that mode value is written to the mode control of all 2*NDIR cells.
- R7: On a match with mode symbol 1 (test), the value 1 is written only to the cells whose enable symbol equals 1. The other cells keep their mode.
- R8: On a match, a mux symbol of 1 writes mux control 0, a mux symbol of 2 writes 1, and a mux symbol of 0 or 3 leaves that mux control unchanged.
- R9: Each written mode or mux channel raises its own strobe for exactly one cycle, together with the new value. Unwritten channels keep their value and strobe low.
- R10: A matching frame whose mode symbol is 3 writes no mode control, but its mux symbols still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming symbol valid |
| in_sym | input | 2 | Incoming configuration symbol |
| in_ready | output | 1 | Controller can take a symbol |
| out_valid | output | 1 | Forwarded symbol valid |
| out_sym | output | 2 | Symbol forwarded to next controller |
| out_ready | input | 1 | Next controller can take a symbol |
| in_mode | output | 2*NDIR | Mode of each input cell, 2 bits per direction |
| in_mode_vld | output | NDIR | One-cycle write strobe per input cell mode |
| in_mux | output | NDIR | Mux control of each input cell |
| in_mux_vld | output | NDIR | One-cycle write strobe per input cell mux |
| out_mode | output | 2*NDIR | Mode of each output cell, 2 bits per direction |
| out_mode_vld | output | NDIR | One-cycle write strobe per output cell mode |
| out_mux | output | NDIR | Mux control of each output cell |
| out_mux_vld | output | NDIR | One-cycle write strobe per output cell mux |

## Verification
The bench builds the controller with `NDIR=5`, `ID_DIGITS=3` and `NODE_ID=5`. This gives a 25-position frame and an address whose three digits (0, 1, 2) are all different. A digit-order or digit-value mistake in the identifier compare therefore shows up, and a frame for address 0 is a true mismatch. The five directions let mixed per-cell enables and mux symbols land on distinct cells. This exposes any swap of direction, field or input/output side. The forwarded stream is compared symbol by symbol across eight frames and a stalled output, which covers the shift order and the handshake.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam logic [1:0] SYM_EOF = 2'd3;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_TEST   = 2'd1;
  localparam logic [1:0] MODE_BYPASS = 2'd2;

  // number of 2-bit positions in one configuration frame
  function automatic int frame_len(input int ndir, input int id_digits);
    return 4 * ndir + id_digits + 2;
  endfunction

endpackage

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int FL = 25
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_sym,
  output logic            in_ready,
  output logic            out_valid,
  output logic [1:0]      out_sym,
  input  logic            out_ready,
  output logic [2*FL-1:0] frame_q,
  output logic            shift_pulse
);
  localparam int FW = 2 * FL;

  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q     <= '0;
      out_valid   <= 1'b0;
      out_sym     <= 2'd0;
      shift_pulse <= 1'b0;
    end else begin
      shift_pulse <= accept;
      if (accept) begin
        frame_q   <= {in_sym, frame_q[FW-1:2]};
        out_sym   <= frame_q[1:0];
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));

  // R3
  top_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (frame_q[FW-1 -: 2] == $past(in_sym)));

  // R3
  drop_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_sym == $past(frame_q[1:0])));

endmodule

// File: rtl/scfg_decoder.sv
module scfg_decoder #(
  parameter int NDIR      = 5,
  parameter int ID_DIGITS = 3,
  parameter int NODE_ID   = 0
) (
  input  logic [2*scfg_pkg::frame_len(NDIR, ID_DIGITS)-1:0] frame,
  input  logic            shift_pulse,
  output logic [1:0]      mode_sym,
  output logic [NDIR-1:0] in_mode_wr,
  output logic [NDIR-1:0] in_mux_wr,
  output logic [NDIR-1:0] in_mux_val,
  output logic [NDIR-1:0] out_mode_wr,
  output logic [NDIR-1:0] out_mux_wr,
  output logic [NDIR-1:0] out_mux_val
);
  import scfg_pkg::*;

  localparam int FL     = frame_len(NDIR, ID_DIGITS);
  localparam int FW     = 2 * FL;
  localparam int ID_LSP = 4 * NDIR + 1;

  logic [ID_DIGITS-1:0] id_ok;
  logic                 match;
  logic                 mode_ok;

  for (genvar k = 0; k < ID_DIGITS; k++) begin : g_id
    localparam int DIG = (NODE_ID / (3 ** k)) % 3;
    assign id_ok[k] = (frame[2*(ID_LSP+k) +: 2] == DIG[1:0]);
  end

  assign mode_sym = frame[1:0];
  assign match    = shift_pulse && (frame[FW-1 -: 2] == SYM_EOF) && (&id_ok);
  assign mode_ok  = match && (mode_sym != SYM_EOF);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [1:0] i_mux, i_en, o_mux, o_en;
    assign i_mux = frame[2*(4*d+1) +: 2];
    assign i_en  = frame[2*(4*d+2) +: 2];
    assign o_mux = frame[2*(4*d+3) +: 2];
    assign o_en  = frame[2*(4*d+4) +: 2];

    assign in_mode_wr[d]  = mode_ok && ((mode_sym != MODE_TEST) || (i_en == 2'd1));
    assign out_mode_wr[d] = mode_ok && ((mode_sym != MODE_TEST) || (o_en == 2'd1));
    assign in_mux_wr[d]   = match && (i_mux == 2'd1 || i_mux == 2'd2);
    assign out_mux_wr[d]  = match && (o_mux == 2'd1 || o_mux == 2'd2);
    assign in_mux_val[d]  = (i_mux == 2'd2);
    assign out_mux_val[d] = (o_mux == 2'd2);
  end

endmodule

// File: rtl/scfg_cell_bank.sv
module scfg_cell_bank #(
  parameter int NDIR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NDIR-1:0]   mode_wr,
  input  logic [1:0]        mode_val,
  input  logic [NDIR-1:0]   mux_wr,
  input  logic [NDIR-1:0]   mux_val,
  output logic [2*NDIR-1:0] mode_q,
  output logic [NDIR-1:0]   mode_vld,
  output logic [NDIR-1:0]   mux_q,
  output logic [NDIR-1:0]   mux_vld
);
  import scfg_pkg::*;

  for (genvar i = 0; i < NDIR; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[2*i +: 2] <= MODE_NORMAL;
        mode_vld[i]      <= 1'b0;
        mux_q[i]         <= 1'b0;
        mux_vld[i]       <= 1'b0;
      end else begin
        mode_vld[i] <= mode_wr[i];
        mux_vld[i]  <= mux_wr[i];
        if (mode_wr[i]) mode_q[2*i +: 2] <= mode_val;
        if (mux_wr[i])  mux_q[i]         <= mux_val[i];
      end
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !mode_wr[i] |=> ($stable(mode_q[2*i +: 2]) && !mode_vld[i]));

    // R9
    mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !mux_wr[i] |=> ($stable(mux_q[i]) && !mux_vld[i]));

    // R10
    mode_range_chk: assert property (@(posedge clk) disable iff (rst)
      mode_q[2*i +: 2] != SYM_EOF);
  end

endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl #(
  parameter int NDIR      = 5,
  parameter int ID_DIGITS = 3,
  parameter int NODE_ID   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_sym,
  output logic              in_ready,
  output logic              out_valid,
  output logic [1:0]        out_sym,
  input  logic              out_ready,
  output logic [2*NDIR-1:0] in_mode,
  output logic [NDIR-1:0]   in_mode_vld,
  output logic [NDIR-1:0]   in_mux,
  output logic [NDIR-1:0]   in_mux_vld,
  output logic [2*NDIR-1:0] out_mode,
  output logic [NDIR-1:0]   out_mode_vld,
  output logic [NDIR-1:0]   out_mux,
  output logic [NDIR-1:0]   out_mux_vld
);
  localparam int FL = scfg_pkg::frame_len(NDIR, ID_DIGITS);

  logic [2*FL-1:0] frame_q;
  logic            shift_pulse;
  logic [1:0]      mode_sym;
  logic [NDIR-1:0] i_mode_wr, i_mux_wr, i_mux_val;
  logic [NDIR-1:0] o_mode_wr, o_mux_wr, o_mux_val;

  scfg_shifter #(.FL(FL)) u_shift (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sym(in_sym), .in_ready(in_ready),
    .out_valid(out_valid), .out_sym(out_sym), .out_ready(out_ready),
    .frame_q(frame_q), .shift_pulse(shift_pulse)
  );

  scfg_decoder #(.NDIR(NDIR), .ID_DIGITS(ID_DIGITS), .NODE_ID(NODE_ID)) u_dec (
    .frame(frame_q), .shift_pulse(shift_pulse), .mode_sym(mode_sym),
    .in_mode_wr(i_mode_wr), .in_mux_wr(i_mux_wr), .in_mux_val(i_mux_val),
    .out_mode_wr(o_mode_wr), .out_mux_wr(o_mux_wr), .out_mux_val(o_mux_val)
  );

  scfg_cell_bank #(.NDIR(NDIR)) u_in_bank (
    .clk(clk), .rst(rst),
    .mode_wr(i_mode_wr), .mode_val(mode_sym),
    .mux_wr(i_mux_wr), .mux_val(i_mux_val),
    .mode_q(in_mode), .mode_vld(in_mode_vld),
    .mux_q(in_mux), .mux_vld(in_mux_vld)
  );

  scfg_cell_bank #(.NDIR(NDIR)) u_out_bank (
    .clk(clk), .rst(rst),
    .mode_wr(o_mode_wr), .mode_val(mode_sym),
    .mux_wr(o_mux_wr), .mux_val(o_mux_val),
    .mode_q(out_mode), .mode_vld(out_mode_vld),
    .mux_q(out_mux), .mux_vld(out_mux_vld)
  );

  // R5
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|{in_mode_vld, in_mux_vld, out_mode_vld, out_mux_vld}) |-> $past(in_valid && in_ready, 2));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_mode == '0 && out_mode == '0 && in_mux == '0 && out_mux == '0));

endmodule

// File: tb/tb_scfg_ctrl.sv
module tb_scfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NDIR = 5;
  localparam int IDD  = 3;
  localparam int FL   = 25;
  localparam int NENT = 8;
  localparam logic [5:0] ID_ME    = 6'b00_01_10; // 5 = 0*9 + 1*3 + 2
  localparam logic [5:0] ID_OTHER = 6'b00_00_00;

  // entry fields: {id(6), mode(2), out_en(10), out_mux(10), in_en(10), in_mux(10)}, dir d at [2d+1:2d]
  localparam logic [47:0] TBL [NENT] = '{
    {ID_ME,    2'd0, 10'd0, 10'd0, 10'd0, 10'd0},
    {ID_ME,    2'd1, 10'b0001000000, 10'b0001000000, 10'b0000000001, 10'b0001000010},
    {ID_OTHER, 2'd2, 10'd0, {5{2'd2}}, 10'd0, {5{2'd2}}},
    {ID_ME,    2'd2, 10'd0, {5{2'd2}}, 10'd0, {5{2'd2}}},
    {ID_ME,    2'd1, {5{2'd1}}, {5{2'd1}}, {5{2'd1}}, {5{2'd1}}},
    {ID_ME,    2'd1, 10'd0, 10'd0, 10'd0, 10'd0},
    {ID_ME,    2'd3, {5{2'd1}}, 10'd0, 10'd0, 10'b0000100000},
    {ID_ME,    2'd0, {5{2'd2}}, 10'd0, 10'd0, 10'b0000001000}
  };
  localparam string TAG [NENT] = '{"R6", "R4/R7", "R5", "R8", "R7", "R7", "R10", "R6"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_sym = 2'd0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [1:0] out_sym;
  logic [2*NDIR-1:0] in_mode, out_mode;
  logic [NDIR-1:0] in_mode_vld, in_mux, in_mux_vld, out_mode_vld, out_mux, out_mux_vld;

  int nchk = 0;
  int nfail = 0;
  logic [1:0] cap [0:255];
  int ncap = 0;
  logic [1:0] sent [0:255];
  int nsent = 0;

  logic [2*NDIR-1:0] e_imode, e_omode;
  logic [NDIR-1:0]   e_imux, e_omux;
  logic [NDIR-1:0]   s_imode, s_omode, s_imux, s_omux;

  always #(CLK_PERIOD/2) clk = ~clk;

  scfg_ctrl #(.NDIR(NDIR), .ID_DIGITS(IDD), .NODE_ID(5)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym), .in_ready(in_ready),
    .out_valid(out_valid), .out_sym(out_sym), .out_ready(out_ready),
    .in_mode(in_mode), .in_mode_vld(in_mode_vld), .in_mux(in_mux), .in_mux_vld(in_mux_vld),
    .out_mode(out_mode), .out_mode_vld(out_mode_vld), .out_mux(out_mux), .out_mux_vld(out_mux_vld)
  );

  // forwarded symbols, sampled a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && out_valid && out_ready && ncap < 256) begin
      cap[ncap] = out_sym;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_sym(input logic [1:0] s);
    in_valid = 1'b1;
    in_sym   = s;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    if (nsent < 256) begin
      sent[nsent] = s;
      nsent++;
    end
  endtask

  // R4: frame layout by position
  function automatic logic [2*FL-1:0] build(input logic [47:0] e);
    logic [2*FL-1:0] f;
    f = '0;
    f[1:0] = e[41:40];
    for (int d = 0; d < NDIR; d++) begin
      f[2*(4*d+1) +: 2] = e[2*d +: 2];        // in mux
      f[2*(4*d+2) +: 2] = e[10 + 2*d +: 2];   // in enable
      f[2*(4*d+3) +: 2] = e[20 + 2*d +: 2];   // out mux
      f[2*(4*d+4) +: 2] = e[30 + 2*d +: 2];   // out enable
    end
    f[2*21 +: 6] = e[47:42];
    f[2*FL-1 -: 2] = 2'd3;
    return f;
  endfunction

  task automatic model(input logic [47:0] e);
    logic [1:0] md;
    logic hit;
    md  = e[41:40];
    hit = (e[47:42] == ID_ME);
    s_imode = '0; s_omode = '0; s_imux = '0; s_omux = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (hit && md != 2'd3 && (md != 2'd1 || e[10 + 2*d +: 2] == 2'd1)) begin
        e_imode[2*d +: 2] = md; s_imode[d] = 1'b1;
      end
      if (hit && md != 2'd3 && (md != 2'd1 || e[30 + 2*d +: 2] == 2'd1)) begin
        e_omode[2*d +: 2] = md; s_omode[d] = 1'b1;
      end
      if (hit && (e[2*d +: 2] == 2'd1 || e[2*d +: 2] == 2'd2)) begin
        e_imux[d] = (e[2*d +: 2] == 2'd2); s_imux[d] = 1'b1;
      end
      if (hit && (e[20 + 2*d +: 2] == 2'd1 || e[20 + 2*d +: 2] == 2'd2)) begin
        e_omux[d] = (e[20 + 2*d +: 2] == 2'd2); s_omux[d] = 1'b1;
      end
    end
  endtask

  initial begin
    logic [2*FL-1:0] f;
    logic [63:0] act, exp;
    bit ok;
    int base;

    e_imode = '0; e_omode = '0; e_imux = '0; e_omux = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    act = {in_mode, in_mux, out_mode, out_mux, in_mode_vld, in_mux_vld, out_mode_vld, out_mux_vld, out_valid};
    chk(act == 64'd0 && in_ready, "R1", "state after reset", act, 64'd0);

    for (int n = 0; n < NENT; n++) begin
      f = build(TBL[n]);
      for (int p = 0; p < FL; p++) send_sym(f[2*p +: 2]);
      in_valid = 1'b0;
      model(TBL[n]);
      @(negedge clk);
      act = {in_mode, in_mux, out_mode, out_mux};
      exp = {e_imode, e_imux, e_omode, e_omux};
      chk(act == exp, TAG[n], $sformatf("controls entry %0d", n), act, exp);
      act = {in_mode_vld, in_mux_vld, out_mode_vld, out_mux_vld};
      exp = {s_imode, s_imux, s_omode, s_omux};
      chk(act == exp, "R9", $sformatf("strobes entry %0d", n), act, exp);
      @(negedge clk);
      act = {in_mode_vld, in_mux_vld, out_mode_vld, out_mux_vld};
      chk(act == 64'd0, "R9", $sformatf("strobes drop entry %0d", n), act, 64'd0);
    end

    // R3: forwarded stream = 25 reset zeros, then each frame one frame later
    ok = (ncap == NENT * FL);
    for (int i = 0; i < ncap && i < 256; i++) begin
      if (i < FL) begin
        if (cap[i] != 2'd0) ok = 0;
      end else if (cap[i] != sent[i - FL]) ok = 0;
    end
    chk(ok, "R3", "forwarded chain stream", 64'(ncap), 64'(NENT * FL));

    // R2: backpressure; next five forwarded symbols are the last frame's positions 0..4
    base = ncap;
    f = build(TBL[NENT-1]);
    out_ready = 1'b0;
    send_sym(2'd0);
    #1;
    chk(!in_ready && out_valid, "R2", "stall blocks input", {62'd0, in_ready, out_valid}, 64'd1);
    repeat (3) @(negedge clk);
    #1;
    chk(!in_ready && out_valid && out_sym == f[1:0], "R2", "stall holds output",
        {61'd0, in_ready, out_sym}, {62'd0, f[1:0]});
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) send_sym(2'd0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    ok = (ncap == base + 5);
    for (int k = 0; k < 5 && ok; k++) if (cap[base + k] != f[2*k +: 2]) ok = 0;
    chk(ok, "R2", "no loss or duplication across stall", 64'(ncap - base), 64'd5);

    // R1: reset after a configured state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    act = {in_mode, in_mux, out_mode, out_mux, out_valid};
    chk(act == 64'd0, "R1", "state after mid-run reset", act, 64'd0);

    finish_run();
  end

endmodule